// File: doc/BRIEF.md
# Eight-Bit Timer with Compare Output

This block is a free-standing 8-bit timer/counter with a single compare channel. It is driven by a system clock and counts only on a tick-enable strobe. A clock-select field picks the strobe from a small vector of pre-divided tick inputs. Four counting modes are available: free-running wrap, clear-on-compare, single-slope PWM and dual-slope PWM. A waveform generator turns compare matches, wrap events and the count direction into a level on one output pin.

Software reaches the block through a simple register port: a write strobe with address and data, and a combinational read mux. An overflow flag and a compare flag each raise an interrupt request when their own enable and a global enable input are set. Each flag clears on an acknowledge pulse or on a write of one to its bit. Top and bottom indications are provided for neighbouring logic.

Top module: `tmr8_oc`

## Requirements
- R1: Clock select 0 stops the counter. Clock select k (1..7) advances it only on clock cycles where tick_i[k-1] is high.
- R2: Register map, at any time: address 0 is the counter, 1 the compare value, 2 control, 3 interrupt. Control holds clock select in [2:0], mode in [4:3], output mode in [6:5] and a force strobe in bit 7 that always reads 0. Interrupt holds the overflow flag in bit 0, the compare flag in bit 1, the overflow enable in bit 2 and the compare enable in bit 3.
- R3: A counter write overrides the tick in the same cycle. The written value is loaded, and that tick's count, flag and waveform actions are dropped.
- R4: Modes: 00 counts up and wraps 0xFF to 0x00. 10 counts up and goes to 0 on the tick taken while the count equals the compare value. 11 counts up and wraps. 01 counts up to 0xFF, then down to 0x00, then up again.
- R5: top_o is high exactly while the count is 0xFF, and bottom_o is high exactly while it is 0x00.
- R6: The overflow flag sets on a tick taken at 0xFF in modes 00, 10 and 11, and on a tick taken at 0x00 in mode 01. irq_ovf_o equals the overflow flag AND its enable AND gie_i.
- R7: The compare flag sets on a tick taken while the count equals the compare value. Reaching equality without a further tick does not set it.
- R8: irq_cmp_o equals the compare flag AND its enable AND gie_i.
- R9: A flag clears on its acknowledge pulse or on a write of 1 to its bit. Writing 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R10: In modes 00 and 10, a match tick applies the output mode to the pin state: 01 toggles, 10 clears, 11 sets. With output mode 00, wave_o is 0.
- R11: In mode 11 with output mode 10, the pin clears on a match tick and sets on the wrap tick. Output mode 11 gives the inverse. A compare value of 0x00 holds the inactive level and 0xFF holds the active level.
- R12: In mode 01 with output mode 10, the pin clears on a match tick while counting up and sets on one while counting down. Output mode 11 gives the inverse. Compare values 0x00 and 0xFF give constant levels as in R11.
- R13: A force strobe applies the match action one clock after its write, in modes 00 and 10 only, and never sets the compare flag. In PWM modes it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 7 | Candidate tick strobes, chosen by clock select |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | CNT_W | Read data, combinational |
| gie_i | input | 1 | Global interrupt enable |
| ack_ovf_i | input | 1 | Overflow interrupt acknowledge |
| ack_cmp_i | input | 1 | Compare interrupt acknowledge |
| wave_o | output | 1 | Compare waveform pin |
| top_o | output | 1 | Count is at maximum |
| bottom_o | output | 1 | Count is zero |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cmp_o | output | 1 | Compare interrupt request |

## Verification
The bench builds the block with its default 8-bit count width and 3-bit clock select. This keeps a full wrap within a few hundred ticks, so wraps, the dual-slope turn at 0xFF and the 0x00/0xFF compare extremes can all be reached directly. The vector table sweeps every counting mode across wrap and match boundaries and predicts both flags for each case. Directed cases then cover write-versus-tick collisions, set-versus-clear collisions, tick-source selection and every output-mode action, including the constant PWM levels.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    localparam int CS_W  = 3;
    localparam int NTICK = (1 << CS_W) - 1;

    localparam logic [1:0] A_CNT  = 2'd0;
    localparam logic [1:0] A_CMP  = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_IRQ  = 2'd3;

    typedef enum logic [1:0] {
        WM_NORMAL = 2'b00,
        WM_PHASE  = 2'b01,
        WM_CTC    = 2'b10,
        WM_FAST   = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        CO_OFF    = 2'b00,
        CO_TOGGLE = 2'b01,
        CO_CLEAR  = 2'b10,
        CO_SET    = 2'b11
    } cout_e;

    typedef struct packed {
        logic            force_s;
        cout_e           com;
        wmode_e          mode;
        logic [CS_W-1:0] cs;
    } ctrl_t;

    typedef struct packed {
        logic cmp_en;
        logic ovf_en;
        logic cmp_f;
        logic ovf_f;
    } irq_t;

    function automatic logic is_pwm(wmode_e m);
        return (m == WM_PHASE) || (m == WM_FAST);
    endfunction

endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] cmp,
    input  wmode_e           mode,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up,
    output logic             step,
    output logic             ovf_evt,
    output logic             match_evt
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] nxt;
    logic             nxt_dir;
    logic             match;
    logic             at_ovf;

    assign step      = tick_en & ~wr_cnt;
    assign match     = (cnt == cmp);
    assign at_ovf    = (mode == WM_PHASE) ? (cnt == '0) : (cnt == MAXV);
    assign ovf_evt   = step & at_ovf;
    assign match_evt = step & match;

    always_comb begin
        nxt     = cnt + 1'b1;
        nxt_dir = dir_up;
        case (mode)
            WM_CTC: if (match) nxt = '0;
            WM_PHASE: begin
                if (dir_up) begin
                    if (cnt == MAXV) begin
                        nxt_dir = 1'b0;
                        nxt     = cnt - 1'b1;
                    end
                end else if (cnt == '0) begin
                    nxt_dir = 1'b1;
                end else begin
                    nxt = cnt - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else begin
            if (wr_cnt) begin
                cnt <= wr_data;
            end else if (step) begin
                cnt    <= nxt;
                dir_up <= nxt_dir;
            end
            if (mode != WM_PHASE) dir_up <= 1'b1;
        end
    end

    assert_write_wins_R3: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt == $past(wr_data)));

    assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_cnt) |=> $stable(cnt));

    assert_normal_step_R4: assert property (@(posedge clk) disable iff (rst)
        (step && mode == WM_NORMAL) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags (
    input  logic clk,
    input  logic rst,
    input  logic ovf_set,
    input  logic cmp_set,
    input  logic ovf_clr,
    input  logic cmp_clr,
    input  logic ovf_en,
    input  logic cmp_en,
    input  logic gie,
    output logic ovf_f,
    output logic cmp_f,
    output logic irq_ovf,
    output logic irq_cmp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_f <= 1'b0;
            cmp_f <= 1'b0;
        end else begin
            if (ovf_set)      ovf_f <= 1'b1;
            else if (ovf_clr) ovf_f <= 1'b0;
            if (cmp_set)      cmp_f <= 1'b1;
            else if (cmp_clr) cmp_f <= 1'b0;
        end
    end

    assign irq_ovf = ovf_f & ovf_en & gie;
    assign irq_cmp = cmp_f & cmp_en & gie;

    assert_ovf_set_R6: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> ovf_f);

    assert_cmp_set_R7: assert property (@(posedge clk) disable iff (rst)
        cmp_set |=> cmp_f);

    assert_cmp_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (cmp_clr && !cmp_set) |=> !cmp_f);

endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  wmode_e           mode,
    input  cout_e            com,
    input  logic             step,
    input  logic             force_p,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             wave_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic wave_q, wave_d, pwm, match, act_lvl;

    assign pwm     = is_pwm(mode);
    assign match   = (cnt == cmp);
    assign act_lvl = (com == CO_CLEAR);

    function automatic logic match_action(cout_e c, logic cur);
        case (c)
            CO_TOGGLE: return ~cur;
            CO_CLEAR:  return 1'b0;
            CO_SET:    return 1'b1;
            default:   return cur;
        endcase
    endfunction

    always_comb begin
        wave_d = wave_q;
        if (!pwm) begin
            if ((step && match) || force_p) wave_d = match_action(com, wave_q);
        end else if (step && (com == CO_CLEAR || com == CO_SET)) begin
            if (cmp == '0)               wave_d = ~act_lvl;
            else if (cmp == MAXV)        wave_d = act_lvl;
            else if (mode == WM_FAST) begin
                if (match)               wave_d = ~act_lvl;
                else if (cnt == MAXV)    wave_d = act_lvl;
            end else if (match)          wave_d = dir_up ? ~act_lvl : act_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wave_q <= 1'b0;
        else     wave_q <= wave_d;
    end

    assign wave_o = (com == CO_OFF || (pwm && com == CO_TOGGLE)) ? 1'b0 : wave_q;

    assert_toggle_R10: assert property (@(posedge clk) disable iff (rst)
        (!pwm && com == CO_TOGGLE && step && match && !force_p) |=> (wave_q != $past(wave_q)));

    assert_pwm_noforce_R13: assert property (@(posedge clk) disable iff (rst)
        (pwm && force_p && !step) |=> $stable(wave_q));

    assert_fast_const_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == WM_FAST && com == CO_CLEAR && cmp == MAXV && step) |=> wave_q);

endmodule

// File: rtl/tmr8_oc.sv
module tmr8_oc
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTICK-1:0] tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    input  logic             gie_i,
    input  logic             ack_ovf_i,
    input  logic             ack_cmp_i,
    output logic             wave_o,
    output logic             top_o,
    output logic             bottom_o,
    output logic             irq_ovf_o,
    output logic             irq_cmp_o
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int IRQ_W  = $bits(irq_t);
    localparam logic [CNT_W-1:0] MAXV = '1;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q, cnt;
    logic             ovf_en_q, cmp_en_q, force_q;
    logic             tick_en, wr_cnt, wr_ctrl, wr_irq;
    logic             dir_up, step, ovf_evt, match_evt;
    logic             ovf_f, cmp_f;
    irq_t             irq_view;

    assign wr_cnt  = wr_en_i && wr_addr_i == A_CNT;
    assign wr_ctrl = wr_en_i && wr_addr_i == A_CTRL;
    assign wr_irq  = wr_en_i && wr_addr_i == A_IRQ;

    always_comb begin
        tick_en = 1'b0;
        for (int k = 1; k <= NTICK; k++)
            if (ctrl_q.cs == CS_W'(k)) tick_en = tick_i[k-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cmp_q    <= '0;
            ovf_en_q <= 1'b0;
            cmp_en_q <= 1'b0;
            force_q  <= 1'b0;
        end else begin
            force_q <= wr_ctrl && wr_data_i[CTRL_W-1];
            if (wr_ctrl) begin
                ctrl_q         <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
                ctrl_q.force_s <= 1'b0;
            end
            if (wr_en_i && wr_addr_i == A_CMP) cmp_q <= wr_data_i;
            if (wr_irq) begin
                ovf_en_q <= wr_data_i[2];
                cmp_en_q <= wr_data_i[3];
            end
        end
    end

    tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_cnt(wr_cnt),
        .wr_data(wr_data_i), .cmp(cmp_q), .mode(ctrl_q.mode),
        .cnt(cnt), .dir_up(dir_up), .step(step),
        .ovf_evt(ovf_evt), .match_evt(match_evt)
    );

    tmr8_flags u_flags (
        .clk(clk), .rst(rst),
        .ovf_set(ovf_evt), .cmp_set(match_evt),
        .ovf_clr(ack_ovf_i || (wr_irq && wr_data_i[0])),
        .cmp_clr(ack_cmp_i || (wr_irq && wr_data_i[1])),
        .ovf_en(ovf_en_q), .cmp_en(cmp_en_q), .gie(gie_i),
        .ovf_f(ovf_f), .cmp_f(cmp_f),
        .irq_ovf(irq_ovf_o), .irq_cmp(irq_cmp_o)
    );

    tmr8_wavegen #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode), .com(ctrl_q.com),
        .step(step), .force_p(force_q), .dir_up(dir_up),
        .cnt(cnt), .cmp(cmp_q), .wave_o(wave_o)
    );

    assign top_o    = (cnt == MAXV);
    assign bottom_o = (cnt == '0);

    always_comb begin
        irq_view = '{cmp_en: cmp_en_q, ovf_en: ovf_en_q, cmp_f: cmp_f, ovf_f: ovf_f};
        case (rd_addr_i)
            A_CNT:   rd_data_o = cnt;
            A_CMP:   rd_data_o = cmp_q;
            A_CTRL:  rd_data_o = CNT_W'(ctrl_q);
            default: rd_data_o = CNT_W'(irq_view[IRQ_W-1:0]);
        endcase
    end

    assert_force_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> !ctrl_q.force_s);

endmodule

// File: tb/tmr8_oc_tb_top.sv
module tmr8_oc_tb_top;
    import tmr8_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NTICK-1:0] tick_i = '0;
    logic             wr_en_i = 1'b0;
    logic [1:0]       wr_addr_i = '0;
    logic [CNT_W-1:0] wr_data_i = '0;
    logic [1:0]       rd_addr_i = '0;
    logic [CNT_W-1:0] rd_data_o;
    logic             gie_i = 1'b0, ack_ovf_i = 1'b0, ack_cmp_i = 1'b0;
    logic             wave_o, top_o, bottom_o, irq_ovf_o, irq_cmp_o;

    tmr8_oc #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .gie_i(gie_i), .ack_ovf_i(ack_ovf_i),
        .ack_cmp_i(ack_cmp_i), .wave_o(wave_o), .top_o(top_o),
        .bottom_o(bottom_o), .irq_ovf_o(irq_ovf_o), .irq_cmp_o(irq_cmp_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // {mode, start, cmp, ticks, expected count, expected ovf flag, expected cmp flag}
    localparam logic [35:0] VEC [8] = '{
        {2'b00, 8'hFE, 8'h80, 8'd3,  8'h01, 1'b1, 1'b0},
        {2'b00, 8'h10, 8'h12, 8'd5,  8'h15, 1'b0, 1'b1},
        {2'b10, 8'h03, 8'h05, 8'd4,  8'h01, 1'b0, 1'b1},
        {2'b10, 8'h00, 8'h20, 8'd33, 8'h00, 1'b0, 1'b1},
        {2'b11, 8'hFF, 8'h80, 8'd1,  8'h00, 1'b1, 1'b0},
        {2'b01, 8'hFD, 8'h80, 8'd4,  8'hFD, 1'b0, 1'b0},
        {2'b01, 8'hFF, 8'hFE, 8'd3,  8'hFC, 1'b0, 1'b1},
        {2'b01, 8'h00, 8'h02, 8'd2,  8'h02, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr_i = a;
        #1;
        v = rd_data_o;
    endtask

    task automatic ticks(input int n);
        tick_i[0] = 1'b1;
        repeat (n) @(negedge clk);
        tick_i[0] = 1'b0;
    endtask

    function automatic logic [7:0] ctl(logic [1:0] m, logic [1:0] c, logic [2:0] cs, logic f);
        return {f, c, m, cs};
    endfunction

    task automatic setwave(input logic v);
        wr(A_CTRL, ctl(2'b00, v ? 2'b11 : 2'b10, 3'd0, 1'b1));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(A_CNT, v);  chk("R2 reset count", v, 8'h00);
        rd(A_CTRL, v); chk("R2 reset control", v, 8'h00);
        rd(A_IRQ, v);  chk("R2 reset irq reg", v, 8'h00);
        chk("R5 reset bottom", bottom_o, 1'b1);
        chk("R10 reset wave", wave_o, 1'b0);

        // vector table: counting modes and flag timing (R4, R6, R7)
        for (int i = 0; i < 8; i++) begin
            logic [35:0] e;
            e = VEC[i];
            wr(A_CTRL, 8'h00);
            wr(A_CNT, e[33:26]);
            wr(A_CMP, e[25:18]);
            wr(A_IRQ, 8'h03);
            wr(A_CTRL, ctl(e[35:34], 2'b00, 3'd1, 1'b0));
            ticks(int'(e[17:10]));
            rd(A_CNT, v); chk($sformatf("R4 vec %0d count", i), v, e[9:2]);
            rd(A_IRQ, v);
            chk($sformatf("R6 vec %0d ovf flag", i), v[0], e[1]);
            chk($sformatf("R7 vec %0d cmp flag", i), v[1], e[0]);
        end

        // R1: tick source selection
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'h20);
        tick_i = '1; repeat (5) @(negedge clk); tick_i = '0;
        rd(A_CNT, v); chk("R1 stopped", v, 8'h20);
        wr(A_CTRL, ctl(2'b00, 2'b00, 3'd2, 1'b0));
        tick_i = 7'b0000001; repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R1 wrong source ignored", v, 8'h20);
        tick_i = 7'b0000010; repeat (3) @(negedge clk); tick_i = '0;
        rd(A_CNT, v); chk("R1 selected source", v, 8'h23);

        // R2: register readback
        wr(A_CMP, 8'hA5);
        rd(A_CMP, v); chk("R2 compare readback", v, 8'hA5);
        wr(A_CTRL, 8'h9B);
        rd(A_CTRL, v); chk("R2 control readback force 0", v, 8'h1B);
        wr(A_CTRL, 8'h00);

        // R3: counter write beats tick
        wr(A_CNT, 8'h40); wr(A_CMP, 8'h40); wr(A_IRQ, 8'h03);
        wr(A_CTRL, ctl(2'b00, 2'b00, 3'd1, 1'b0));
        tick_i[0] = 1'b1;
        wr(A_CNT, 8'h90);
        tick_i[0] = 1'b0;
        rd(A_CNT, v); chk("R3 write wins", v, 8'h90);
        rd(A_IRQ, v); chk("R3 no cmp flag", v[1], 1'b0);

        // R5: top and bottom
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'hFF);
        chk("R5 top", {top_o, bottom_o}, 2'b10);
        wr(A_CNT, 8'h00);
        chk("R5 bottom", {top_o, bottom_o}, 2'b01);
        wr(A_CNT, 8'h05);
        chk("R5 neither", {top_o, bottom_o}, 2'b00);

        // R6: overflow interrupt request
        wr(A_CNT, 8'hFF); wr(A_IRQ, 8'h07);
        gie_i = 1'b1;
        wr(A_CTRL, ctl(2'b00, 2'b00, 3'd1, 1'b0));
        ticks(1);
        chk("R6 irq ovf", irq_ovf_o, 1'b1);
        gie_i = 1'b0; #1;
        chk("R6 irq ovf gated by gie", irq_ovf_o, 1'b0);

        // R8 and R9: compare request and clearing
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'h30); wr(A_CMP, 8'h30); wr(A_IRQ, 8'h0B);
        gie_i = 1'b1;
        wr(A_CTRL, ctl(2'b00, 2'b00, 3'd1, 1'b0));
        tick_i[0] = 1'b1; ack_cmp_i = 1'b1;
        @(negedge clk);
        tick_i[0] = 1'b0; ack_cmp_i = 1'b0;
        chk("R9 set wins over ack", irq_cmp_o, 1'b1);
        chk("R8 irq cmp", irq_cmp_o, 1'b1);
        ack_cmp_i = 1'b1; @(negedge clk); ack_cmp_i = 1'b0;
        chk("R9 ack clears", irq_cmp_o, 1'b0);
        wr(A_CNT, 8'h30); ticks(1);
        wr(A_IRQ, 8'h00);
        rd(A_IRQ, v); chk("R9 write zero keeps flag", v[1], 1'b1);
        chk("R8 irq cmp off when disabled", irq_cmp_o, 1'b0);
        wr(A_IRQ, 8'h02);
        rd(A_IRQ, v); chk("R9 write one clears", v[1], 1'b0);
        gie_i = 1'b0;

        // R13: force in non-PWM mode, no flag
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'h40); wr(A_CMP, 8'h40); wr(A_IRQ, 8'h03);
        setwave(1'b1);
        chk("R13 force sets pin", wave_o, 1'b1);
        rd(A_IRQ, v); chk("R13 force no flag", v[1], 1'b0);

        // R10: output mode off, toggle, set in CTC
        wr(A_CTRL, 8'h00);
        chk("R10 disconnected", wave_o, 1'b0);
        setwave(1'b0);
        wr(A_CNT, 8'h05); wr(A_CMP, 8'h05);
        wr(A_CTRL, ctl(2'b00, 2'b01, 3'd1, 1'b0));
        ticks(1);
        chk("R10 toggle on match", wave_o, 1'b1);
        ticks(1);
        chk("R10 no toggle off match", wave_o, 1'b1);
        setwave(1'b0);
        wr(A_CNT, 8'h07); wr(A_CMP, 8'h07);
        wr(A_CTRL, ctl(2'b10, 2'b11, 3'd1, 1'b0));
        ticks(1);
        chk("R10 set on match", wave_o, 1'b1);
        rd(A_CNT, v); chk("R4 ctc clears", v, 8'h00);

        // R13: force ignored in PWM
        setwave(1'b0);
        wr(A_CTRL, ctl(2'b11, 2'b11, 3'd0, 1'b1));
        @(negedge clk);
        chk("R13 force ignored in fast pwm", wave_o, 1'b0);

        // R11: fast PWM
        setwave(1'b0);
        wr(A_CNT, 8'hFF); wr(A_CMP, 8'h03);
        wr(A_CTRL, ctl(2'b11, 2'b10, 3'd1, 1'b0));
        ticks(1);
        chk("R11 set at wrap", wave_o, 1'b1);
        ticks(3);
        chk("R11 held before match", wave_o, 1'b1);
        ticks(1);
        chk("R11 clear at match", wave_o, 1'b0);
        setwave(1'b1);
        wr(A_CNT, 8'hFE); wr(A_CMP, 8'h00);
        wr(A_CTRL, ctl(2'b11, 2'b10, 3'd1, 1'b0));
        ticks(3);
        chk("R11 cmp zero constant low", wave_o, 1'b0);
        setwave(1'b0);
        wr(A_CMP, 8'hFF);
        wr(A_CTRL, ctl(2'b11, 2'b10, 3'd1, 1'b0));
        ticks(3);
        chk("R11 cmp max constant high", wave_o, 1'b1);

        // R12: phase-correct PWM
        setwave(1'b1);
        wr(A_CNT, 8'h0E); wr(A_CMP, 8'h10);
        wr(A_CTRL, ctl(2'b01, 2'b10, 3'd1, 1'b0));
        ticks(3);
        chk("R12 clear on up match", wave_o, 1'b0);
        wr(A_CNT, 8'hFF);
        ticks(1);
        rd(A_CNT, v); chk("R4 phase turns at top", v, 8'hFE);
        wr(A_CNT, 8'h11);
        ticks(2);
        chk("R12 set on down match", wave_o, 1'b1);
        rd(A_CNT, v); chk("R4 phase counting down", v, 8'h0F);
        setwave(1'b0);
        wr(A_CMP, 8'hFF);
        wr(A_CTRL, ctl(2'b01, 2'b10, 3'd1, 1'b0));
        ticks(5);
        chk("R12 cmp max constant high", wave_o, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule